// File: doc/BRIEF.md
# UART Receive Status and Error Flag Unit

This block is the receive half of an asynchronous serial port, together with the status flags a host polls. A 16x oversampling shifter synchronises the serial line and confirms a start bit at mid-bit. It shifts in eight data bits, least significant first, then an optional parity bit, then a stop bit. When a frame completes, the flag unit loads a one-byte receive buffer. It also updates six status flags: receiving, receive-finished, error-summary, overrun, parity error and framing error.

The host has three controls. It reads the buffer through a one-cycle read strobe. It sets or clears a receive-enable bit through a write strobe. It chooses the parity mode through two configuration inputs. How flags are cleared depends on overrun history. With no overrun, a buffer read clears the finished flag and the error flags. Once an overrun is flagged, buffer reads clear nothing, and only clearing receive-enable returns the unit to a clean state.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, all six status flags, `rx_en` and `rd_data` are 0.
- R2: While `rx_en` is 0, the serial line is ignored and every flag reads 0. A write of 0 to receive-enable (`ctl_we`=1, `ctl_val`=0) clears all flags on that edge, including overrun. `rd_data` is not cleared.
- R3: A frame of a low start bit, 8 data bits LSB first, an optional parity bit and a high stop bit loads the data into `rd_data` and sets `st_done`. `st_busy` falls on the edge where the stop bit is sampled.
- R4: `st_busy` rises only when the line is still low at the middle of the start bit. A low pulse shorter than half a bit period starts nothing.
- R5: With `par_en`=1, a parity bit follows the data. It is even parity when `par_odd`=0 and odd parity when `par_odd`=1. A mismatch sets `st_par`. With `par_en`=0 no parity bit is expected and `st_par` stays 0.
- R6: A stop bit sampled as 0 sets `st_frm`, and the data byte is still loaded.
- R7: `st_err_sum` is 1 exactly when any of `st_ovr`, `st_par` or `st_frm` is 1.
- R8: Without an overrun, a `buf_rd` strobe clears `st_done`, `st_par` and `st_frm`.
- R9: A frame that completes while `st_done` is set, with no read in that cycle, sets `st_ovr`. The buffer keeps its earlier byte, and the new byte and its errors are discarded.
- R10: While `st_ovr` is set, `buf_rd` strobes change no flag.
- R11: A `buf_rd` in the same cycle as a frame completion acts first. The new frame then loads normally, `st_done` stays set and no overrun results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_in | input | 1 | Serial receive line, idle high |
| par_en | input | 1 | 1: a parity bit follows the data bits |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| ctl_we | input | 1 | Write strobe for the receive-enable bit |
| ctl_val | input | 1 | Value written to receive-enable |
| buf_rd | input | 1 | One-cycle strobe: host reads the buffer's lower byte |
| rd_data | output | DATA_W | Receive buffer contents |
| rx_en | output | 1 | Current receive-enable bit |
| st_busy | output | 1 | Frame reception in progress |
| st_done | output | 1 | Receive-finished flag |
| st_err_sum | output | 1 | Error summary |
| st_ovr | output | 1 | Overrun error |
| st_par | output | 1 | Parity error |
| st_frm | output | 1 | Framing error |

## Verification
The bench receives every byte value and checks both the load and the read-clear. A wrong bit order or a missing shift step would corrupt some of those bytes. It covers both parity senses with good and flipped parity bits. A reversed parity sense would flag the good frames and pass the bad ones. It sends a start glitch shorter than half a bit, which a receiver without mid-bit confirmation would take as a frame. It raises a read in exactly the completion cycle. A design that orders the read after the frame would report a false overrun. After an overrun it reads again and then disables. A design that clears the flags on the read, or that leaves the overrun set after the disable, fails there.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
   typedef enum logic [2:0] {
      RS_IDLE  = 3'd0,
      RS_START = 3'd1,
      RS_DATA  = 3'd2,
      RS_PARB  = 3'd3,
      RS_STOP  = 3'd4
   } rx_state_e;

   // parity error: data XOR received bit XOR odd-select must be 0
   function automatic logic par_mismatch(input logic dpar, input logic pbit, input logic odd);
      return dpar ^ pbit ^ odd;
   endfunction
endpackage

// File: rtl/uart_rxs_sync.sv
module uart_rxs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2+((STAGES==1)?1:0):0], d_in} ;
         end
         assign d_out = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_rxs_shifter.sv
module uart_rxs_shifter
   import uart_rxs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rxd,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              busy,
   output logic              fc,
   output logic [DATA_W-1:0] f_data,
   output logic              f_perr,
   output logic              f_ferr
);
   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);
   localparam logic [BIT_W-1:0] LAST_B  = BIT_W'(DATA_W - 1);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_w
         $error("DATA_W must be 5..9");
      end
   endgenerate

   rx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic              tick;

   assign tick = (cnt == FULL_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RS_IDLE;
         cnt    <= '0;
         bitn   <= '0;
         shreg  <= '0;
         pbit   <= 1'b0;
         busy   <= 1'b0;
         fc     <= 1'b0;
         f_data <= '0;
         f_perr <= 1'b0;
         f_ferr <= 1'b0;
      end else begin
         fc <= 1'b0;
         if (!en) begin
            st   <= RS_IDLE;
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            unique case (st)
               RS_IDLE: begin
                  cnt <= '0;
                  if (!rxd) st <= RS_START;
               end
               RS_START: begin
                  if (cnt == HALF_M1) begin
                     cnt <= '0;
                     if (!rxd) begin
                        st   <= RS_DATA;
                        busy <= 1'b1;
                        bitn <= '0;
                     end else begin
                        st <= RS_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RS_DATA: begin
                  if (tick) begin
                     cnt   <= '0;
                     shreg <= {rxd, shreg[DATA_W-1:1]};
                     bitn  <= bitn + 1'b1;
                     if (bitn == LAST_B) st <= par_en ? RS_PARB : RS_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RS_PARB: begin
                  if (tick) begin
                     cnt  <= '0;
                     pbit <= rxd;
                     st   <= RS_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RS_STOP: begin
                  if (tick) begin
                     cnt    <= '0;
                     st     <= RS_IDLE;
                     busy   <= 1'b0;
                     fc     <= 1'b1;
                     f_data <= shreg;
                     f_ferr <= ~rxd;
                     f_perr <= par_en & par_mismatch(^shreg, pbit, par_odd);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RS_IDLE;
            endcase
         end
      end
   end

   AST_BUSY_FALL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(en)) |-> fc); // R3
   AST_NO_PAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (fc && !$past(par_en)) |-> !f_perr); // R5
   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(rxd)); // R4
endmodule

// File: rtl/uart_rxs_flags.sv
module uart_rxs_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              ctl_val,
   input  logic              buf_rd,
   input  logic              fc,
   input  logic [DATA_W-1:0] f_data,
   input  logic              f_perr,
   input  logic              f_ferr,
   output logic              rx_en,
   output logic              done,
   output logic              ovr,
   output logic              perr,
   output logic              ferr,
   output logic [DATA_W-1:0] buf_q
);
   logic wipe;
   logic rd_eff;

   assign wipe   = !rx_en || (ctl_we && !ctl_val);
   assign rd_eff = buf_rd && !ovr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en <= 1'b0;
         done  <= 1'b0;
         ovr   <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
         buf_q <= '0;
      end else begin
         if (ctl_we) rx_en <= ctl_val;
         if (wipe) begin
            done <= 1'b0;
            ovr  <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
         end else if (fc) begin
            if (done && !rd_eff) begin
               ovr <= 1'b1;
            end else begin
               buf_q <= f_data;
               done  <= 1'b1;
               perr  <= f_perr;
               ferr  <= f_ferr;
            end
         end else if (rd_eff) begin
            done <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
         end
      end
   end

   AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !(done || ovr || perr || ferr)); // R2
   AST_OVR_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> done); // R9
   AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && rx_en) |=> $stable(buf_q)); // R9
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && rx_en && !(ctl_we && !ctl_val)) |=> (ovr && done)); // R10
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd && !ovr && !fc) |=> !done); // R8
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_in,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              ctl_we,
   input  logic              ctl_val,
   input  logic              buf_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_en,
   output logic              st_busy,
   output logic              st_done,
   output logic              st_err_sum,
   output logic              st_ovr,
   output logic              st_par,
   output logic              st_frm
);
   logic              rxd_s;
   logic              busy_raw;
   logic              fc;
   logic [DATA_W-1:0] f_data;
   logic              f_perr;
   logic              f_ferr;

   uart_rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(rxd_in), .d_out(rxd_s)
   );

   uart_rxs_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .rxd(rxd_s),
      .par_en(par_en), .par_odd(par_odd), .busy(busy_raw), .fc(fc),
      .f_data(f_data), .f_perr(f_perr), .f_ferr(f_ferr)
   );

   uart_rxs_flags #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_val(ctl_val),
      .buf_rd(buf_rd), .fc(fc), .f_data(f_data), .f_perr(f_perr),
      .f_ferr(f_ferr), .rx_en(rx_en), .done(st_done), .ovr(st_ovr),
      .perr(st_par), .ferr(st_frm), .buf_q(rd_data)
   );

   assign st_busy    = busy_raw & rx_en;
   assign st_err_sum = st_ovr | st_par | st_frm;

   AST_ERRSUM_TRACKS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_par) |-> st_err_sum); // R7
endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
   localparam int OVS = 8;
   localparam int DW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rxd_in = 1'b1, par_en = 1'b0, par_odd = 1'b0;
   logic ctl_we = 1'b0, ctl_val = 1'b0, buf_rd = 1'b0;
   logic [DW-1:0] rd_data;
   logic rx_en, st_busy, st_done, st_err_sum, st_ovr, st_par, st_frm;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   uart_rx_status #(.DATA_W(DW), .OVS(OVS), .SYNC_STAGES(2)) u_uart_rx_status (
      .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .par_en(par_en), .par_odd(par_odd),
      .ctl_we(ctl_we), .ctl_val(ctl_val), .buf_rd(buf_rd), .rd_data(rd_data),
      .rx_en(rx_en), .st_busy(st_busy), .st_done(st_done), .st_err_sum(st_err_sum),
      .st_ovr(st_ovr), .st_par(st_par), .st_frm(st_frm)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // flags packed as {busy,done,sum,ovr,par,frm}
   function automatic logic [5:0] flags();
      return {st_busy, st_done, st_err_sum, st_ovr, st_par, st_frm};
   endfunction

   task automatic hold_bit(input logic v);
      rxd_in = v;
      repeat (OVS) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic pe, input logic odd,
                       input logic bad_par, input logic stop);
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(d[i]);
      if (pe) hold_bit((^d) ^ odd ^ bad_par);
      hold_bit(stop);
      rxd_in = 1'b1;
      repeat (2 * OVS) @(negedge clk);
   endtask

   task automatic rd_pulse();
      buf_rd = 1'b1;
      @(negedge clk);
      buf_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr_en(input logic v);
      ctl_we = 1'b1; ctl_val = v;
      @(negedge clk);
      ctl_we = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags", {26'd0, flags()}, 32'd0);
      chk("R1 data", {24'd0, rd_data}, 32'd0);
      chk("R1 rx_en", {31'd0, rx_en}, 32'd0);

      // R2: disabled receiver ignores line
      send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R2 ignored flags", {26'd0, flags()}, 32'd0);
      chk("R2 ignored data", {24'd0, rd_data}, 32'd0);

      wr_en(1'b1);
      chk("R2 enabled", {31'd0, rx_en}, 32'd1);

      // R3/R8: sweep every byte, no parity
      for (int b = 0; b < 256; b++) begin
         send(8'(b), 1'b0, 1'b0, 1'b0, 1'b1);
         chk("R3 data", {24'd0, rd_data}, 32'(b));
         chk("R3 flags", {26'd0, flags()}, 32'b010000);
         rd_pulse();
         chk("R8 read clears", {26'd0, flags()}, 32'd0);
      end

      // R4: short glitch does not start a frame
      rxd_in = 1'b0;
      repeat (2) @(negedge clk);
      rxd_in = 1'b1;
      repeat (3 * OVS) @(negedge clk);
      chk("R4 glitch busy", {31'd0, st_busy}, 32'd0);
      chk("R4 glitch done", {31'd0, st_done}, 32'd0);
      // R4: busy high mid-frame
      fork
         send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
         begin
            repeat (3 * OVS) @(negedge clk);
            chk("R4 busy mid-frame", {31'd0, st_busy}, 32'd1);
         end
      join
      chk("R3 busy fell", {31'd0, st_busy}, 32'd0);
      chk("R3 data 3C", {24'd0, rd_data}, 32'h3C);
      rd_pulse();

      // R5/R7/R8: parity sweep
      par_en = 1'b1;
      for (int k = 0; k < 64; k++) begin
         for (int m = 0; m < 4; m++) begin
            logic [7:0] d;
            d = 8'((k * 37 + m * 11) & 8'hFF);
            par_odd = m[0];
            send(d, 1'b1, m[0], m[1], 1'b1);
            chk("R5 data", {24'd0, rd_data}, {24'd0, d});
            chk("R5 parity flag", {31'd0, st_par}, {31'd0, m[1]});
            chk("R7 sum", {31'd0, st_err_sum}, {31'd0, m[1]});
            rd_pulse();
            chk("R8 par cleared", {26'd0, flags()}, 32'd0);
         end
      end
      par_en = 1'b0;
      par_odd = 1'b0;

      // R6: framing error still loads data
      send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 data", {24'd0, rd_data}, 32'h5A);
      chk("R6 flags", {26'd0, flags()}, 32'b011001);
      rd_pulse();
      chk("R8 frm cleared", {26'd0, flags()}, 32'd0);

      // R9/R10: overrun
      send(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
      send(8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R9 flags", {26'd0, flags()}, 32'b011100);
      chk("R9 buffer kept", {24'd0, rd_data}, 32'h11);
      rd_pulse();
      chk("R10 read no clear", {26'd0, flags()}, 32'b011100);
      send(8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R10 still kept", {24'd0, rd_data}, 32'h11);
      wr_en(1'b0);
      chk("R2 disable clears", {26'd0, flags()}, 32'd0);
      chk("R2 data kept", {24'd0, rd_data}, 32'h11);
      wr_en(1'b1);

      // R11: read in the completion cycle
      send(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
      fork
         send(8'h99, 1'b0, 1'b0, 1'b0, 1'b1);
         begin
            logic prev;
            prev = 1'b0;
            forever begin
               @(negedge clk);
               if (prev && !st_busy) break;
               prev = st_busy;
            end
            buf_rd = 1'b1;
            @(negedge clk);
            buf_rd = 1'b0;
         end
      join
      chk("R11 flags", {26'd0, flags()}, 32'b010000);
      chk("R11 data", {24'd0, rd_data}, 32'h99);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule